// File: doc/BRIEF.md
# Min-Sum Variable Node Accumulator

This block is the variable-node side of a layered min-sum decoder, sized for one code bit. It keeps the bit's a priori value and, for every layer that touches the bit's column, the last outgoing variable-to-check magnitude and sign and the last check-to-variable value. It cycles through two phases. In the first it sends one outgoing message per layer. In the second it takes back one message per layer from the check-node side. Each returning message carries a first minimum, a second minimum and a sign product. The unit turns each one back into a check-to-variable value. It picks the second minimum when its own stored outgoing magnitude equals the first minimum, and the first minimum otherwise. The sign is the received sign product XOR its own stored outgoing sign. Each value is added to a running sum that starts from the a priori value.

Only after every layer of the column has reported does the unit publish the new posterior total and the hard decision, and then start the next round of outgoing messages. Each outgoing message is the total minus that layer's own incoming value, folded into sign-magnitude form. At a super-iteration boundary, the caller can replace the a priori value with the extrinsic value returned from the exchange unit.

The controller has three states: IDLE (after reset), EMIT (sending one message per layer) and COLLECT (absorbing one check message per layer). The transitions are:
- IDLE→EMIT on `prior_load`.
- EMIT→COLLECT after the last layer has been sent.
- COLLECT→EMIT after the last layer has been absorbed.
- EMIT→EMIT and COLLECT→EMIT on `prior_load`, which restarts the code bit.

Top module: `vna_top`

## Requirements
- R1: While reset is held and right after it, `phase_o` is 0 (IDLE), `v2c_valid` is 0, `post_o` is 0 and `hard_o` is 0.
- R2: A `prior_load` pulse is taken in any state. From the next cycle `post_o` equals `prior_in`, `phase_o` is 1 (EMIT), and over the following LAYERS cycles one message per cycle appears with `v2c_layer` counting 0,1,…,LAYERS-1.
- R3: The message for layer k is total − c2v[k], where c2v[k] is the last value absorbed for layer k (0 after a load). It is sent as a sign bit (`v2c_sign`=1 means negative) and a magnitude clipped to 31. A zero difference is sent with sign 0.
- R4: After the last message is sent, `phase_o` is 2 (COLLECT). Each cycle with `cn_valid` high then absorbs the check message for the next layer, in order 0,1,…,LAYERS-1.
- R5: The magnitude of a rebuilt check-to-variable value is `cn_min2` when the stored outgoing magnitude of that layer equals `cn_min1`, and `cn_min1` otherwise.
- R6: A rebuilt value is negative when `cn_sign` XOR the stored outgoing sign of that layer is 1.
- R7: Absorption starts from the a priori value. Each rebuilt value is added with saturation to the signed 8-bit range −128..127 at every step. After the last layer, `post_o` shows the sum and `phase_o` returns to 1.
- R8: `hard_o` is 1 exactly when `post_o` is negative.
- R9: An `ext_load` pulse in COLLECT before any layer has been absorbed replaces both the a priori value and the running sum with `ext_in`. A `cn_valid` in that same cycle is dropped. An `ext_load` after the first absorbed layer, or outside COLLECT, is ignored.
- R10: `cn_valid` is ignored outside COLLECT.
- R11: `v2c_valid` is low in every cycle that does not follow an EMIT cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prior_load | input | 1 | Start a new code bit with `prior_in` |
| prior_in | input | 8 | Channel a priori value, two's complement |
| ext_load | input | 1 | Replace the a priori value at a super iteration |
| ext_in | input | 8 | Extrinsic value from the exchange unit |
| cn_valid | input | 1 | Check message for the current layer is present |
| cn_min1 | input | 5 | First minimum magnitude |
| cn_min2 | input | 5 | Second minimum magnitude |
| cn_sign | input | 1 | Sign product from the check node |
| v2c_valid | output | 1 | Outgoing message valid |
| v2c_layer | output | 2 | Layer index of the outgoing message |
| v2c_sign | output | 1 | Outgoing sign, 1 = negative |
| v2c_mag | output | 5 | Outgoing magnitude |
| post_o | output | 8 | Posterior total, two's complement |
| hard_o | output | 1 | Hard decision |
| phase_o | output | 2 | Controller state: 0 IDLE, 1 EMIT, 2 COLLECT |

## Verification
The bench first targets the marginalization rule. It covers layers whose first minimum equals the stored outgoing magnitude, including a stored magnitude of zero. A unit that always took the first minimum would return the bit's own contribution, and its totals would drift. The bench also drives a running sum that saturates at +127 or −128 partway through a round and then falls back. A design that clipped only at the end, or wrapped instead, shows a different posterior.

Other checks cover the super-iteration replace:
- the accepted case;
- the case that collides with a check message;
- the late case that must be ignored.

Further checks cover check messages arriving during emission, and a restart in the middle of a round. A design that got these wrong would absorb stray messages or keep stale per-layer state.

// File: rtl/vna_pkg.sv
package vna_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_EMIT    = 2'd1,
        PH_COLLECT = 2'd2
    } vna_phase_e;

endpackage

// File: rtl/vna_select.sv
// Rebuilds one check-to-variable value from the two minima and the sign
// product, using the variable's own stored outgoing message.
module vna_select #(
    parameter int MAG_W = 5
) (
    input  logic [MAG_W-1:0]       prev_mag,
    input  logic                   prev_sign,
    input  logic [MAG_W-1:0]       min1,
    input  logic [MAG_W-1:0]       min2,
    input  logic                   cn_sign,
    output logic signed [MAG_W:0]  c2v
);
    logic [MAG_W-1:0] pick;
    logic             neg;
    logic signed [MAG_W:0] pos_val;

    always_comb begin
        // own contribution was the first minimum: use the runner-up
        pick    = (prev_mag == min1) ? min2 : min1;
        neg     = cn_sign ^ prev_sign;
        pos_val = $signed({1'b0, pick});
        c2v     = neg ? -pos_val : pos_val;
    end
endmodule

// File: rtl/vna_sat_add.sv
// Two's complement add that clamps to the signed range of the result width.
module vna_sat_add #(
    parameter int ACC_W = 8,
    parameter int ADD_W = 6
) (
    input  logic signed [ACC_W-1:0] a,
    input  logic signed [ADD_W-1:0] b,
    output logic signed [ACC_W-1:0] y
);
    localparam int EXT_W = ACC_W + 1 - ADD_W;

    logic signed [ACC_W:0] wide;
    logic                  ovf;

    always_comb begin
        wide = {a[ACC_W-1], a} + {{EXT_W{b[ADD_W-1]}}, b};
        ovf  = wide[ACC_W] ^ wide[ACC_W-1];
        if (!ovf)
            y = wide[ACC_W-1:0];
        else if (wide[ACC_W])
            y = {1'b1, {(ACC_W-1){1'b0}}};
        else
            y = {1'b0, {(ACC_W-1){1'b1}}};
    end
endmodule

// File: rtl/vna_msg_form.sv
// Forms an outgoing message: total minus the layer's own incoming value,
// folded to sign-magnitude with the magnitude clipped to MAG_W bits.
module vna_msg_form #(
    parameter int ACC_W = 8,
    parameter int MAG_W = 5
) (
    input  logic signed [ACC_W-1:0] total,
    input  logic signed [MAG_W:0]   c2v,
    output logic                    sign,
    output logic [MAG_W-1:0]        mag
);
    localparam int EXT_W = ACC_W - MAG_W;
    localparam logic [ACC_W:0] CAP = (ACC_W+1)'((1 << MAG_W) - 1);

    logic signed [ACC_W:0] diff;
    logic        [ACC_W:0] absval;

    always_comb begin
        diff   = {total[ACC_W-1], total} - {{EXT_W{c2v[MAG_W]}}, c2v};
        sign   = diff[ACC_W];
        absval = sign ? (~diff + 1'b1) : diff;
        mag    = (absval > CAP) ? CAP[MAG_W-1:0] : absval[MAG_W-1:0];
    end
endmodule

// File: rtl/vna_top.sv
module vna_top #(
    parameter int LAYERS = 4,
    parameter int ACC_W  = 8,
    parameter int MAG_W  = 5,
    localparam int LW    = (LAYERS > 1) ? $clog2(LAYERS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prior_load,
    input  logic [ACC_W-1:0]  prior_in,
    input  logic              ext_load,
    input  logic [ACC_W-1:0]  ext_in,
    input  logic              cn_valid,
    input  logic [MAG_W-1:0]  cn_min1,
    input  logic [MAG_W-1:0]  cn_min2,
    input  logic              cn_sign,
    output logic              v2c_valid,
    output logic [LW-1:0]     v2c_layer,
    output logic              v2c_sign,
    output logic [MAG_W-1:0]  v2c_mag,
    output logic [ACC_W-1:0]  post_o,
    output logic              hard_o,
    output logic [1:0]        phase_o
);
    import vna_pkg::*;

    localparam int C2V_W = MAG_W + 1;
    localparam logic [LW-1:0] LAST = LW'(LAYERS - 1);

    vna_phase_e state_q, state_d;

    logic [LW-1:0]            cnt_q;
    logic signed [ACC_W-1:0]  prior_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  total_q;

    logic                     v2c_valid_q;
    logic [LW-1:0]            v2c_layer_q;
    logic                     v2c_sign_q;
    logic [MAG_W-1:0]         v2c_mag_q;

    // per-layer storage seen through flat arrays
    logic                     sgn_mem [LAYERS];
    logic [MAG_W-1:0]         mag_mem [LAYERS];
    logic signed [C2V_W-1:0]  c2v_mem [LAYERS];

    logic                     at_last;
    logic                     in_emit;
    logic                     in_collect;
    logic                     ext_take;
    logic                     cn_take;
    logic                     emit_fire;

    logic                     cur_sgn;
    logic [MAG_W-1:0]         cur_mag;
    logic signed [C2V_W-1:0]  cur_c2v;
    logic signed [C2V_W-1:0]  c2v_new;
    logic signed [ACC_W-1:0]  acc_next;
    logic                     form_sign;
    logic [MAG_W-1:0]         form_mag;

    // ---------------------------------------------------------------
    // control qualifiers
    // ---------------------------------------------------------------
    always_comb begin
        at_last    = (cnt_q == LAST);
        in_emit    = (state_q == PH_EMIT);
        in_collect = (state_q == PH_COLLECT);
        ext_take   = !prior_load && in_collect && ext_load && (cnt_q == '0);
        cn_take    = !prior_load && in_collect && cn_valid && !ext_take;
        emit_fire  = !prior_load && in_emit;
    end

    // ---------------------------------------------------------------
    // current-layer view
    // ---------------------------------------------------------------
    always_comb begin
        cur_sgn = sgn_mem[0];
        cur_mag = mag_mem[0];
        cur_c2v = c2v_mem[0];
        for (int i = 0; i < LAYERS; i++) begin
            if (cnt_q == LW'(i)) begin
                cur_sgn = sgn_mem[i];
                cur_mag = mag_mem[i];
                cur_c2v = c2v_mem[i];
            end
        end
    end

    vna_select #(.MAG_W(MAG_W)) u_select (
        .prev_mag  (cur_mag),
        .prev_sign (cur_sgn),
        .min1      (cn_min1),
        .min2      (cn_min2),
        .cn_sign   (cn_sign),
        .c2v       (c2v_new)
    );

    vna_sat_add #(.ACC_W(ACC_W), .ADD_W(C2V_W)) u_sat_add (
        .a (acc_q),
        .b (c2v_new),
        .y (acc_next)
    );

    vna_msg_form #(.ACC_W(ACC_W), .MAG_W(MAG_W)) u_form (
        .total (total_q),
        .c2v   (cur_c2v),
        .sign  (form_sign),
        .mag   (form_mag)
    );

    // ---------------------------------------------------------------
    // per-layer registers
    // ---------------------------------------------------------------
    for (genvar k = 0; k < LAYERS; k++) begin : g_layer
        logic                    sgn_q;
        logic [MAG_W-1:0]        mag_q;
        logic signed [C2V_W-1:0] c2v_q;
        logic                    hit;

        assign hit = (cnt_q == LW'(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sgn_q <= 1'b0;
                mag_q <= '0;
                c2v_q <= '0;
            end else if (prior_load) begin
                c2v_q <= '0;
            end else begin
                if (emit_fire && hit) begin
                    sgn_q <= form_sign;
                    mag_q <= form_mag;
                end
                if (cn_take && hit)
                    c2v_q <= c2v_new;
            end
        end

        assign sgn_mem[k] = sgn_q;
        assign mag_mem[k] = mag_q;
        assign c2v_mem[k] = c2v_q;
    end

    // ---------------------------------------------------------------
    // state register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PH_IDLE;
        else
            state_q <= state_d;
    end

    // ---------------------------------------------------------------
    // next state
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (prior_load)
                    state_d = PH_EMIT;
            end
            PH_EMIT: begin
                if (prior_load)
                    state_d = PH_EMIT;
                else if (at_last)
                    state_d = PH_COLLECT;
            end
            PH_COLLECT: begin
                if (prior_load)
                    state_d = PH_EMIT;
                else if (cn_take && at_last)
                    state_d = PH_EMIT;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // datapath and output registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            prior_q     <= '0;
            acc_q       <= '0;
            total_q     <= '0;
            v2c_valid_q <= 1'b0;
            v2c_layer_q <= '0;
            v2c_sign_q  <= 1'b0;
            v2c_mag_q   <= '0;
        end else begin
            v2c_valid_q <= 1'b0;
            if (prior_load) begin
                prior_q <= prior_in;
                acc_q   <= prior_in;
                total_q <= prior_in;
                cnt_q   <= '0;
            end else begin
                unique case (state_q)
                    PH_IDLE: begin
                        cnt_q <= '0;
                    end
                    PH_EMIT: begin
                        v2c_valid_q <= 1'b1;
                        v2c_layer_q <= cnt_q;
                        v2c_sign_q  <= form_sign;
                        v2c_mag_q   <= form_mag;
                        if (at_last) begin
                            cnt_q <= '0;
                            acc_q <= prior_q;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_COLLECT: begin
                        if (ext_take) begin
                            prior_q <= ext_in;
                            acc_q   <= ext_in;
                        end else if (cn_take) begin
                            acc_q <= acc_next;
                            if (at_last) begin
                                cnt_q   <= '0;
                                total_q <= acc_next;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    assign v2c_valid = v2c_valid_q;
    assign v2c_layer = v2c_layer_q;
    assign v2c_sign  = v2c_sign_q;
    assign v2c_mag   = v2c_mag_q;
    assign post_o    = total_q;
    assign hard_o    = total_q[ACC_W-1];
    assign phase_o   = state_q;

endmodule

// File: rtl/vna_checker.sv
module vna_checker #(
    parameter int ACC_W = 8,
    parameter int MAG_W = 5,
    parameter int LW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prior_load,
    input logic [ACC_W-1:0] prior_in,
    input logic             v2c_valid,
    input logic [LW-1:0]    v2c_layer,
    input logic             v2c_sign,
    input logic [MAG_W-1:0] v2c_mag,
    input logic [ACC_W-1:0] post_o,
    input logic [1:0]       phase_o
);

    p_valid_after_emit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        v2c_valid |-> $past(phase_o) == 2'd1);

    p_no_neg_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (v2c_valid && v2c_mag == '0) |-> !v2c_sign);

    p_layer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (v2c_valid && $past(v2c_valid)) |-> v2c_layer == LW'($past(v2c_layer) + 1'b1));

    p_layer_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (v2c_valid && !$past(v2c_valid)) |-> v2c_layer == '0);

    p_load_enters_emit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prior_load |=> (phase_o == 2'd1 && post_o == $past(prior_in)));

    p_post_held_collect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2 && $past(phase_o) == 2'd2) |-> $stable(post_o));

    p_post_held_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd2 && !prior_load) |=> $stable(post_o));

endmodule

bind vna_top vna_checker #(.ACC_W(ACC_W), .MAG_W(MAG_W), .LW(LW)) u_vna_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prior_load (prior_load),
    .prior_in   (prior_in),
    .v2c_valid  (v2c_valid),
    .v2c_layer  (v2c_layer),
    .v2c_sign   (v2c_sign),
    .v2c_mag    (v2c_mag),
    .post_o     (post_o),
    .phase_o    (phase_o)
);

// File: tb/vna_top_tb_top.sv
`timescale 1ns/1ps
module vna_top_tb_top;
    localparam int L  = 4;
    localparam int AW = 8;
    localparam int MW = 5;
    localparam int NROW = 6;

    // table: rightmost field is layer 0
    localparam logic [AW-1:0] T_PRI [NROW] = '{8'd20, 8'hD8, 8'd120, 8'h88, 8'd0, 8'd7};
    localparam logic [19:0] T_M1 [NROW] = '{
        {5'd3,  5'd20, 5'd10, 5'd20},
        {5'd9,  5'd31, 5'd4,  5'd31},
        {5'd31, 5'd31, 5'd30, 5'd31},
        {5'd31, 5'd31, 5'd31, 5'd31},
        {5'd0,  5'd5,  5'd0,  5'd0},
        {5'd7,  5'd8,  5'd2,  5'd7}};
    localparam logic [19:0] T_M2 [NROW] = '{
        {5'd7,  5'd22, 5'd12, 5'd25},
        {5'd15, 5'd31, 5'd6,  5'd31},
        {5'd31, 5'd31, 5'd31, 5'd31},
        {5'd31, 5'd31, 5'd31, 5'd29},
        {5'd1,  5'd6,  5'd9,  5'd2},
        {5'd8,  5'd8,  5'd3,  5'd9}};
    localparam logic [3:0] T_SG [NROW] = '{4'b1010, 4'b1001, 4'b1110, 4'b1110, 4'b0011, 4'b0110};

    logic clk = 1'b0;
    logic rst_n;
    logic prior_load, ext_load, cn_valid, cn_sign;
    logic [AW-1:0] prior_in, ext_in;
    logic [MW-1:0] cn_min1, cn_min2;
    logic v2c_valid, v2c_sign, hard_o;
    logic [1:0] v2c_layer, phase_o;
    logic [MW-1:0] v2c_mag;
    logic [AW-1:0] post_o;

    always #2 clk = ~clk;

    vna_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .prior_load(prior_load), .prior_in(prior_in),
        .ext_load(ext_load), .ext_in(ext_in),
        .cn_valid(cn_valid), .cn_min1(cn_min1), .cn_min2(cn_min2), .cn_sign(cn_sign),
        .v2c_valid(v2c_valid), .v2c_layer(v2c_layer), .v2c_sign(v2c_sign), .v2c_mag(v2c_mag),
        .post_o(post_o), .hard_o(hard_o), .phase_o(phase_o)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int m_prior, m_acc, m_total, m_cnt;
    int m_sign [L];
    int m_mag  [L];
    int m_c2v  [L];

    function automatic int sat8(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic do_load(input int p);
        @(negedge clk);
        prior_in   = AW'(p);
        prior_load = 1'b1;
        @(negedge clk);
        prior_load = 1'b0;
        m_prior = p; m_total = p; m_acc = p; m_cnt = 0;
        for (int k = 0; k < L; k++) m_c2v[k] = 0;
        check("R2 post after load", int'($signed(post_o)), p);
        check("R2 phase after load", int'(phase_o), 1);
        check("R8 hard after load", int'(hard_o), (p < 0) ? 1 : 0);
    endtask

    task automatic check_emit();
        for (int k = 0; k < L; k++) begin
            int d, es, em;
            d  = m_total - m_c2v[k];
            es = (d < 0) ? 1 : 0;
            em = (d < 0) ? -d : d;
            if (em > 31) em = 31;
            @(posedge clk); #1;
            check("R2 v2c_valid", int'(v2c_valid), 1);
            check("R2 v2c_layer", int'(v2c_layer), k);
            check("R3 v2c_sign", int'(v2c_sign), es);
            check("R3 v2c_mag", int'(v2c_mag), em);
            m_sign[k] = es;
            m_mag[k]  = em;
        end
        m_acc = m_prior;
        m_cnt = 0;
        check("R4 phase collect", int'(phase_o), 2);
    endtask

    task automatic feed(input int m1, input int m2, input int sg);
        int k, sel, neg, c;
        @(negedge clk);
        cn_min1 = MW'(m1); cn_min2 = MW'(m2); cn_sign = sg[0];
        cn_valid = 1'b1;
        @(posedge clk); #1;
        cn_valid = 1'b0;
        check("R11 v2c_valid low in collect", int'(v2c_valid), 0);
        k   = m_cnt;
        sel = (m_mag[k] == m1) ? m2 : m1;           // R5
        neg = sg ^ m_sign[k];                        // R6
        c   = neg ? -sel : sel;
        m_c2v[k] = c;
        m_acc = sat8(m_acc + c);                     // R7
        m_cnt++;
        if (m_cnt == L) begin
            m_total = m_acc;
            m_cnt = 0;
        end
    endtask

    task automatic check_round_end(input string tag);
        check({tag, " R7 post"}, int'($signed(post_o)), m_total);
        check({tag, " R8 hard"}, int'(hard_o), (m_total < 0) ? 1 : 0);
        check({tag, " R7 phase emit"}, int'(phase_o), 1);
    endtask

    task automatic feed_row(input int r);
        for (int k = 0; k < L; k++)
            feed(int'(T_M1[r][k*5 +: 5]), int'(T_M2[r][k*5 +: 5]), int'(T_SG[r][k]));
    endtask

    // watchdog
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R2 act=hung exp=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        prior_load = 1'b0; ext_load = 1'b0; cn_valid = 1'b0; cn_sign = 1'b0;
        prior_in = '0; ext_in = '0; cn_min1 = '0; cn_min2 = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 phase in reset", int'(phase_o), 0);
        check("R1 valid in reset", int'(v2c_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: check messages in IDLE leave the outputs alone
        cn_valid = 1'b1; cn_min1 = 5'd9; cn_min2 = 5'd11;
        repeat (3) @(negedge clk);
        cn_valid = 1'b0;
        check("R1 post after reset", int'(post_o), 0);
        check("R1 hard after reset", int'(hard_o), 0);
        check("R10 phase stays idle", int'(phase_o), 0);
        check("R11 valid idle", int'(v2c_valid), 0);

        // table walk: two rounds per row
        for (int r = 0; r < NROW; r++) begin
            do_load(int'($signed(T_PRI[r])));
            check_emit();
            feed_row(r);
            check_round_end("row first");
            check_emit();
            feed_row(r);
            check_round_end("row second");
            check_emit();
        end

        // R9: accepted super-iteration replace
        do_load(10);
        check_emit();
        @(negedge clk);
        ext_in = AW'(-50); ext_load = 1'b1;
        @(posedge clk); #1;
        ext_load = 1'b0;
        m_prior = -50; m_acc = -50;
        feed_row(5);
        check_round_end("R9 ext accepted");
        check_emit();

        // R9: replace collides with a check message; message dropped
        @(negedge clk);
        ext_in = AW'(33); ext_load = 1'b1;
        cn_valid = 1'b1; cn_min1 = 5'd30; cn_min2 = 5'd31; cn_sign = 1'b1;
        @(posedge clk); #1;
        ext_load = 1'b0; cn_valid = 1'b0;
        m_prior = 33; m_acc = 33;
        feed_row(0);
        check_round_end("R9 ext wins over cn");
        check_emit();

        // R9: late replace is ignored
        feed(4, 6, 0);
        @(negedge clk);
        ext_in = AW'(-100); ext_load = 1'b1;
        @(posedge clk); #1;
        ext_load = 1'b0;
        feed(5, 8, 1);
        feed(2, 3, 0);
        feed(6, 9, 1);
        check_round_end("R9 late ext ignored");
        check_emit();

        // R10: check messages during emission are ignored
        do_load(-17);
        cn_valid = 1'b1; cn_min1 = 5'd1; cn_min2 = 5'd2; cn_sign = 1'b1;
        check_emit();
        cn_valid = 1'b0;
        feed_row(4);
        check_round_end("R10 cn during emit ignored");
        check_emit();

        // R2: restart in the middle of a collect round
        do_load(50);
        check_emit();
        feed(3, 4, 0);
        feed(5, 6, 1);
        do_load(-60);
        check_emit();
        feed_row(1);
        check_round_end("R2 restart");
        check_emit();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule